// File: doc/BRIEF.md
# Stereo Serial Audio Data Port (Slave)

This block is the digital edge of a stereo 24-bit converter pair. An external controller supplies both the bit clock and the frame clock. The block sends converter-bound samples out on a serial output and captures samples arriving on a serial input. Each frame is 64 bit clocks long and holds two 32-clock slots: the left channel while the frame clock is high, then the right channel while it is low. Both directions are two's complement with the MSB first, but they are justified differently within a slot. Outgoing words start at the first bit of the slot and are padded with zeros at its end. Incoming words occupy the last 24 bit clocks of the slot, and the leading bits are ignored.

The bit clock, frame clock and serial input are brought into the block's system clock domain through a synchronizer. Edges are found by comparing each synchronized line with its previous value. On the core side the block takes parallel left and right words to send. It returns parallel left and right words that were received, plus a single-cycle strobe that marks a complete received stereo pair.

Top module: `aud_serial_port`

## Requirements
- R1: The output `sdto_o` carries the left word, bit 23 first, starting right after the frame clock rises. Each following bit, down to bit 0, appears after the next falling bit-clock edge.
- R2: The frame clock selects the channel: high is the left slot and low is the right slot, in both directions. The right transmit word and the right received word belong to the low half of the frame.
- R3: Every frame-clock transition restarts the slot bit count. The first data bit of the new slot is driven from that transition, even when it arrives in the same cycle as a falling bit-clock edge. A frame-clock transition never coincides with a rising bit-clock edge.
- R4: In every slot, `sdto_o` is 0 for bit positions 24 to 31 (counted from 0 at the frame-clock transition).
- R5: `sdti_i` is sampled on rising bit-clock edges. Slot positions 8 to 31 carry the 24-bit word MSB first. Positions 0 to 7 are ignored and do not affect the received word.
- R6: `sdto_o` changes only after a falling bit-clock edge or a frame-clock transition, never after a rising edge.
- R7: Both transmit words are captured when the left slot begins. Changes to `tx_left_i` or `tx_right_i` later in that frame do not affect the frame being sent.
- R8: `rx_pair_vld_o` pulses high for exactly one cycle after the last bit of a right slot. In that same cycle `rx_left_o` and `rx_right_o` present the pair from that frame. The two words hold their values at all other times.
- R9: A pair is reported only when a complete 32-bit left slot came before the right slot in the same frame. A slot cut short by an early frame-clock transition yields no word.
- R10: While `rst_n` is low, `sdto_o`, `rx_left_o`, `rx_right_o` and `rx_pair_vld_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock from the external controller |
| lrck_i | input | 1 | Frame (channel select) clock, high for left |
| sdti_i | input | 1 | Serial input data, LSB-justified in each slot |
| sdto_o | output | 1 | Serial output data, MSB-justified in each slot |
| tx_left_i | input | 24 | Left word to send |
| tx_right_i | input | 24 | Right word to send |
| rx_left_o | output | 24 | Last received left word |
| rx_right_o | output | 24 | Last received right word |
| rx_pair_vld_o | output | 1 | One-cycle strobe marking a new received pair |

## Verification
A frame-clock transition can fall in the same system cycle as a falling bit-clock edge. In that cycle the transmit path must both move past the old slot and load the MSB of the new slot. The bench provokes this by switching the frame clock at the same instant as the bit clock in selected frames. It judges the result from the serial output at the first rising edge of the new slot, which must already show the new word's bit 23. A second overlap is a core-side update of the transmit words while a frame is in flight. This is judged by whether every bit of the current frame still follows the words that were present when the frame started.

// File: rtl/aud_sp_pkg.sv
package aud_sp_pkg;

   typedef enum logic {
      SLOT_LEFT  = 1'b0,
      SLOT_RIGHT = 1'b1
   } slot_e;

   // Maps a frame-clock level onto the channel slot it selects.
   function automatic slot_e slot_of(input logic lvl, input logic left_lvl);
      return (lvl == left_lvl) ? SLOT_LEFT : SLOT_RIGHT;
   endfunction

endpackage

// File: rtl/aud_sp_frontend.sv
module aud_sp_frontend #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic lrck,
   input  logic sdti,
   output logic bclk_rise,
   output logic bclk_fall,
   output logic lr_edge,
   output logic lr_level,
   output logic sdti_s
);

   localparam int NSIG = 3;

   logic [NSIG-1:0] raw;
   logic [NSIG-1:0] syn;
   logic            bclk_q;
   logic            lrck_q;

   assign raw = {sdti, lrck, bclk};

   generate
      if (STAGES == 0) begin : g_bypass
         assign syn = raw;
      end else begin : g_chain
         logic [NSIG-1:0] ff [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) ff[i] <= '0;
            end else begin
               ff[0] <= raw;
               for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
            end
         end
         assign syn = ff[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         lrck_q <= 1'b0;
      end else begin
         bclk_q <= syn[0];
         lrck_q <= syn[1];
      end
   end

   assign bclk_rise = syn[0] & ~bclk_q;
   assign bclk_fall = ~syn[0] & bclk_q;
   assign lr_level  = syn[1];
   assign lr_edge   = syn[1] ^ lrck_q;
   assign sdti_s    = syn[2];

endmodule

// File: rtl/aud_sp_tx.sv
module aud_sp_tx
   import aud_sp_pkg::*;
#(
   parameter int   SAMPLE_W   = 24,
   parameter int   SLOT_W     = 32,
   parameter int   IDX_W      = 6,
   parameter logic LEFT_LEVEL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lr_edge,
   input  logic                lr_level,
   input  logic                bit_fall,
   input  logic [SAMPLE_W-1:0] tx_left,
   input  logic [SAMPLE_W-1:0] tx_right,
   output logic                sdto,
   output logic [IDX_W-1:0]    bit_idx
);

   localparam logic [IDX_W-1:0] SLOT_END = IDX_W'(SLOT_W);
   localparam logic [IDX_W-1:0] PAD_POS  = IDX_W'(SAMPLE_W);

   logic [SAMPLE_W-1:0] shreg;
   logic [SAMPLE_W-1:0] right_hold;
   logic [IDX_W-1:0]    idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         right_hold <= '0;
         idx        <= SLOT_END;
      end else if (lr_edge) begin
         // A new slot wins over any falling edge seen in the same cycle.
         idx <= '0;
         if (slot_of(lr_level, LEFT_LEVEL) == SLOT_LEFT) begin
            shreg      <= tx_left;
            right_hold <= tx_right;
         end else begin
            shreg <= right_hold;
         end
      end else if (bit_fall && idx != SLOT_END) begin
         idx   <= idx + 1'b1;
         shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
      end
   end

   assign sdto    = (idx < PAD_POS) ? shreg[SAMPLE_W-1] : 1'b0;
   assign bit_idx = idx;

endmodule

// File: rtl/aud_sp_rx.sv
module aud_sp_rx
   import aud_sp_pkg::*;
#(
   parameter int   SAMPLE_W   = 24,
   parameter int   SLOT_W     = 32,
   parameter int   IDX_W      = 6,
   parameter logic LEFT_LEVEL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lr_edge,
   input  logic                lr_level,
   input  logic                bit_rise,
   input  logic                sdti,
   output logic [SAMPLE_W-1:0] rx_left,
   output logic [SAMPLE_W-1:0] rx_right,
   output logic                pair_vld
);

   localparam logic [IDX_W-1:0] SLOT_END = IDX_W'(SLOT_W);
   localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(SLOT_W - 1);
   localparam logic [IDX_W-1:0] SKIP_POS = IDX_W'(SLOT_W - SAMPLE_W);

   logic [IDX_W-1:0]    idx;
   logic [SAMPLE_W-1:0] shreg;
   logic [SAMPLE_W-1:0] sh_nxt;
   logic [SAMPLE_W-1:0] left_hold;
   logic                left_ok;
   slot_e               slot_q;
   slot_e               slot_new;

   assign sh_nxt   = {shreg[SAMPLE_W-2:0], sdti};
   assign slot_new = slot_of(lr_level, LEFT_LEVEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx       <= SLOT_END;
         shreg     <= '0;
         left_hold <= '0;
         left_ok   <= 1'b0;
         slot_q    <= SLOT_RIGHT;
         rx_left   <= '0;
         rx_right  <= '0;
         pair_vld  <= 1'b0;
      end else begin
         pair_vld <= 1'b0;
         if (lr_edge) begin
            idx    <= '0;
            slot_q <= slot_new;
            if (slot_new == SLOT_LEFT) left_ok <= 1'b0;
         end else if (bit_rise && idx != SLOT_END) begin
            idx <= idx + 1'b1;
            if (idx >= SKIP_POS) shreg <= sh_nxt;
            if (idx == LAST_POS) begin
               if (slot_q == SLOT_LEFT) begin
                  left_hold <= sh_nxt;
                  left_ok   <= 1'b1;
               end else if (left_ok) begin
                  rx_left  <= left_hold;
                  rx_right <= sh_nxt;
                  pair_vld <= 1'b1;
                  left_ok  <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port #(
   parameter int   SAMPLE_W    = 24,
   parameter int   SLOT_W      = 32,
   parameter int   SYNC_STAGES = 2,
   parameter logic LEFT_LEVEL  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_i,
   input  logic                lrck_i,
   input  logic                sdti_i,
   output logic                sdto_o,
   input  logic [SAMPLE_W-1:0] tx_left_i,
   input  logic [SAMPLE_W-1:0] tx_right_i,
   output logic [SAMPLE_W-1:0] rx_left_o,
   output logic [SAMPLE_W-1:0] rx_right_o,
   output logic                rx_pair_vld_o
);

   localparam int IDX_W = $clog2(SLOT_W + 1);

   generate
      if (SAMPLE_W < 2) begin : g_bad_sample
         $error("SAMPLE_W must be at least 2");
      end
      if (SLOT_W < SAMPLE_W) begin : g_bad_slot
         $error("SLOT_W must not be smaller than SAMPLE_W");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic             bclk_rise;
   logic             bclk_fall;
   logic             lr_edge;
   logic             lr_level;
   logic             sdti_s;
   logic [IDX_W-1:0] tx_idx;

   aud_sp_frontend #(
      .STAGES (SYNC_STAGES)
   ) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk      (bclk_i),
      .lrck      (lrck_i),
      .sdti      (sdti_i),
      .bclk_rise (bclk_rise),
      .bclk_fall (bclk_fall),
      .lr_edge   (lr_edge),
      .lr_level  (lr_level),
      .sdti_s    (sdti_s)
   );

   aud_sp_tx #(
      .SAMPLE_W   (SAMPLE_W),
      .SLOT_W     (SLOT_W),
      .IDX_W      (IDX_W),
      .LEFT_LEVEL (LEFT_LEVEL)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .lr_edge  (lr_edge),
      .lr_level (lr_level),
      .bit_fall (bclk_fall),
      .tx_left  (tx_left_i),
      .tx_right (tx_right_i),
      .sdto     (sdto_o),
      .bit_idx  (tx_idx)
   );

   aud_sp_rx #(
      .SAMPLE_W   (SAMPLE_W),
      .SLOT_W     (SLOT_W),
      .IDX_W      (IDX_W),
      .LEFT_LEVEL (LEFT_LEVEL)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .lr_edge  (lr_edge),
      .lr_level (lr_level),
      .bit_rise (bclk_rise),
      .sdti     (sdti_s),
      .rx_left  (rx_left_o),
      .rx_right (rx_right_o),
      .pair_vld (rx_pair_vld_o)
   );

endmodule

// File: rtl/aud_serial_port_chk.sv
module aud_serial_port_chk #(
   parameter int SAMPLE_W = 24,
   parameter int IDX_W    = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bclk_rise,
   input logic                bclk_fall,
   input logic                lr_edge,
   input logic [IDX_W-1:0]    tx_idx,
   input logic                sdto_o,
   input logic                rx_pair_vld_o,
   input logic [SAMPLE_W-1:0] rx_left_o,
   input logic [SAMPLE_W-1:0] rx_right_o
);

   localparam logic [IDX_W-1:0] PAD_POS = IDX_W'(SAMPLE_W);

   AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n) lr_edge |=> tx_idx == '0); // R3
   AST_LR_NOT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) lr_edge |-> !bclk_rise); // R3
   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (tx_idx >= PAD_POS) |-> !sdto_o); // R4
   AST_SDTO_STEADY: assert property (@(posedge clk) disable iff (!rst_n) !(lr_edge || bclk_fall) |=> $stable(sdto_o)); // R6
   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_pair_vld_o |=> !rx_pair_vld_o); // R8
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rx_pair_vld_o |-> ($stable(rx_left_o) && $stable(rx_right_o))); // R8

endmodule

bind aud_serial_port aud_serial_port_chk #(
   .SAMPLE_W (SAMPLE_W),
   .IDX_W    (IDX_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .bclk_rise     (bclk_rise),
   .bclk_fall     (bclk_fall),
   .lr_edge       (lr_edge),
   .tx_idx        (tx_idx),
   .sdto_o        (sdto_o),
   .rx_pair_vld_o (rx_pair_vld_o),
   .rx_left_o     (rx_left_o),
   .rx_right_o    (rx_right_o)
);

// File: tb/aud_serial_port_tb_top.sv
module aud_serial_port_tb_top;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk  = 1'b0;
   logic        lrck  = 1'b0;
   logic        sdti  = 1'b0;
   logic [23:0] tx_l  = '0;
   logic [23:0] tx_r  = '0;
   logic        sdto;
   logic [23:0] rx_l;
   logic [23:0] rx_r;
   logic        rx_vld;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;
   logic [47:0] exp_q[$];

   always #10 clk = ~clk;

   aud_serial_port dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .bclk_i        (bclk),
      .lrck_i        (lrck),
      .sdti_i        (sdti),
      .sdto_o        (sdto),
      .tx_left_i     (tx_l),
      .tx_right_i    (tx_r),
      .rx_left_o     (rx_l),
      .rx_right_o    (rx_r),
      .rx_pair_vld_o (rx_vld)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [47:0] act, input logic [47:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // One bit clock: fall, data/frame setup, check before rise, check after rise.
   task automatic put_bit(input logic lr, input logic din, input logic exp,
                          input bit together, input string tag);
      @(negedge clk);
      bclk = 1'b0;
      if (together) lrck = lr;
      repeat (3) @(negedge clk);
      lrck = lr;
      sdti = din;
      repeat (5) @(negedge clk);
      check(sdto === exp, tag, "sdto before rise", {47'd0, sdto}, {47'd0, exp});
      bclk = 1'b1;
      repeat (6) @(negedge clk);
      check(sdto === exp, "R6", "sdto after rise", {47'd0, sdto}, {47'd0, exp});
   endtask

   task automatic run_slot(input logic lr, input logic [23:0] txw, input logic [23:0] rxw,
                           input logic [7:0] junk, input int first, input int last,
                           input bit together, input string tag);
      for (int b = first; b < last; b++) begin
         logic  din;
         logic  exp;
         string t;
         din = (b < 8) ? junk[7-b] : rxw[31-b];
         exp = (b < 24) ? txw[23-b] : 1'b0;
         if (tag != "") t = tag;
         else if (b >= 24) t = "R4";
         else t = lr ? "R1" : "R2";
         if (b == 0 && together) t = "R3";
         put_bit(lr, din, exp, together && (b == 0), t);
      end
   endtask

   task automatic run_frame(input logic [23:0] tl, input logic [23:0] tr,
                            input logic [23:0] rl, input logic [23:0] rr,
                            input logic [7:0] junk, input bit together,
                            input bit midchg, input int left_len, input string tag);
      tx_l = tl;
      tx_r = tr;
      if (left_len == 32) exp_q.push_back({rl, rr});
      if (midchg) begin
         run_slot(1'b1, tl, rl, junk, 0, 12, together, tag);
         tx_l = ~tl;  // R7: update while the frame is in flight
         tx_r = ~tr;
         run_slot(1'b1, tl, rl, junk, 12, 32, 1'b0, tag);
      end else begin
         run_slot(1'b1, tl, rl, junk, 0, left_len, together, tag);
      end
      run_slot(1'b0, tr, rr, junk, 0, 32, together, tag);
   endtask

   // Scoreboard monitor: pops the expected pair whenever the strobe fires.
   logic [23:0] last_l = '0;
   logic [23:0] last_r = '0;
   logic [23:0] prev_l = '0;
   logic [23:0] prev_r = '0;
   bit          prev_v = 1'b0;
   logic [47:0] exp_item;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_vld) begin
            check(!prev_v, "R8", "strobe wider than one cycle", 48'd1, 48'd0);
            check(prev_l == last_l && prev_r == last_r, "R8", "words moved before strobe",
                  {prev_l, prev_r}, {last_l, last_r});
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected pair", {rx_l, rx_r}, 48'd0);
            end else begin
               exp_item = exp_q.pop_front();
               check(rx_l == exp_item[47:24], "R5", "left word", {24'd0, rx_l}, {24'd0, exp_item[47:24]});
               check(rx_r == exp_item[23:0], "R2", "right word", {24'd0, rx_r}, {24'd0, exp_item[23:0]});
            end
            last_l = rx_l;
            last_r = rx_r;
         end
         prev_v = rx_vld;
         prev_l = rx_l;
         prev_r = rx_r;
      end
   end

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check(sdto === 1'b0, "R10", "sdto in reset", {47'd0, sdto}, 48'd0);
      check(rx_l === 24'd0 && rx_r === 24'd0, "R10", "rx words in reset", {rx_l, rx_r}, 48'd0);
      check(rx_vld === 1'b0, "R10", "strobe in reset", {47'd0, rx_vld}, 48'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 R2 R5: full-scale extremes, junk in the ignored positions
      run_frame(24'h123456, 24'hABCDEF, 24'h800000, 24'h7FFFFF, 8'hFF, 1'b0, 1'b0, 32, "");
      // R3: frame clock switches together with the falling bit clock
      run_frame(24'h7FFFFF, 24'h800000, 24'h000000, 24'hFFFFFF, 8'hA5, 1'b1, 1'b0, 32, "");
      // R7: transmit words change mid-frame
      run_frame(24'hA5A5A5, 24'h5A5A5A, 24'h13579B, 24'h2468AC, 8'h3C, 1'b0, 1'b1, 32, "R7");
      // R9: left slot cut short, no pair expected
      run_frame(24'hC0FFEE, 24'h0F0F0F, 24'h111111, 24'h222222, 8'hFF, 1'b0, 1'b0, 20, "R9");
      // recovery after the short frame, mixed with coincident edges
      run_frame(24'h000001, 24'hFFFFFE, 24'h000001, 24'hFFFFFE, 8'h81, 1'b1, 1'b0, 32, "");

      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R8", "pairs never reported", 48'(exp_q.size()), 48'd0);
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
         summary();
         $finish;
      end
   end

endmodule